// File: doc/BRIEF.md
# Priority Maskable Interrupt Controller

This block arbitrates a set of maskable interrupt request lines (55 by default) for a processor core. Each source owns a pending latch, a mask bit and a three-bit priority level. A small write port sets the mask bit and the level of one source per cycle. A one-cycle high pulse on a source's request line sets that source's pending latch. Among the sources that are pending and not masked, the block picks the one with the best level. When levels are equal, a fixed order by source index decides.

When the core can take an interrupt, the block issues a one-cycle acknowledge. The acknowledge carries the winning source index and its level. The acknowledged level is pushed on an in-service stack, and an end-of-interrupt strobe from the core pops it. A pending request is forwarded only if it is strictly more urgent than the level on top of the stack. While the core reports interrupts disabled or a non-maskable event in progress, requests stay pending and nothing is forwarded.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source is masked with level 7, no request is pending, nothing is in service (`svc_active`=0) and `ack_valid` is 0.
- R2: A request pulse on a masked source is latched as pending but never acknowledged. Clearing the mask (config write with data bit `cfg_mask`=0) lets it be acknowledged.
- R3: Among eligible sources the lowest numeric level wins. Level 0 is the most urgent and level 7 the least.
- R4: Among eligible sources at the same level, the lowest source index wins.
- R5: While `cpu_id` or `cpu_np` is 1, no acknowledge is issued. One cycle after both are 0, the best pending request is acknowledged.
- R6: While a level is in service, a request is acknowledged only if its level is numerically lower (strictly more urgent). A request at an equal or worse level waits.
- R7: An acknowledge is a single-cycle pulse on `ack_valid` carrying `ack_src` and `ack_lvl`, and it clears that source's pending latch. If a request pulse arrives on the same cycle that the acknowledge is decided, the latch is set again.
- R8: Each acknowledge pushes its level on an in-service stack of 8 entries. `svc_lvl` shows the top entry. An `eoi` pulse pops the top entry, an `eoi` with nothing in service is ignored, and no acknowledge is decided in a cycle where `eoi` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 55 | Per-source request pulses |
| cfg_we | input | 1 | Config write strobe |
| cfg_idx | input | 6 | Source index being configured |
| cfg_mask | input | 1 | Mask bit to write (1 = masked) |
| cfg_lvl | input | 3 | Priority level to write (0 most urgent) |
| cpu_id | input | 1 | Core reports interrupts disabled |
| cpu_np | input | 1 | Core reports non-maskable handling in progress |
| eoi | input | 1 | End of interrupt, pops the in-service level |
| ack_valid | output | 1 | One-cycle acknowledge pulse |
| ack_src | output | 6 | Acknowledged source index |
| ack_lvl | output | 3 | Acknowledged level |
| svc_active | output | 1 | At least one level is in service |
| svc_lvl | output | 3 | Level on top of the in-service stack (0 when empty) |

## Verification
The hardest case to reach from the ports is a new request that lands on the very cycle its own source is being acknowledged. It needs the latch to clear and set again on the same edge. The stimulus holds the request line high for two consecutive cycles on an unmasked source. The first edge latches the request, and the second edge both acknowledges the source and sets the latch again. The surviving pending request is then exposed after an end-of-interrupt. The full eight-deep nest is also driven, with one source per level from 7 down to 0, and `svc_lvl` is checked after each push and pop.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_LOWEST = lvl_t'(NUM_LVL - 1);
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int N_SRC = 55,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       req,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic                   cfg_mask,
  input  lvl_t                   cfg_lvl,
  input  logic                   clr,
  input  logic [IDX_W-1:0]       clr_idx,
  output logic [N_SRC-1:0]       pend,
  output logic [N_SRC-1:0]       mask,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic pend_d, pend_q;
    logic mask_q;
    lvl_t lvl_q;
    logic cfg_hit;
    logic clr_hit;

    always_comb begin
      cfg_hit = cfg_we && (cfg_idx == IDX_W'(i));
      clr_hit = clr && (clr_idx == IDX_W'(i));
      pend_d  = pend_q;
      if (clr_hit) pend_d = 1'b0;
      if (req[i])  pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= 1'b1;
        lvl_q  <= LVL_LOWEST;
      end else if (cfg_hit) begin
        mask_q <= cfg_mask;
        lvl_q  <= cfg_lvl;
      end
    end

    assign pend[i] = pend_q;
    assign mask[i] = mask_q;
    assign lvl[i]  = lvl_q;
  end

  // R2: the arbiter never selects a masked or idle source for clearing
  a_r2_clear_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (pend[clr_idx] && !mask[clr_idx]));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 55,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            cand,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
  output logic                        found,
  output logic [IDX_W-1:0]            win_idx,
  output lvl_t                        win_lvl
);

  // Ascending scan with strict compare: equal levels keep the lower index.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = LVL_LOWEST;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!found || (lvl[i] < win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end

endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic active,
  output lvl_t top_lvl
);

  lvl_t             ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push && (cnt_q < CNT_W'(DEPTH)))  cnt_d = cnt_q + 1'b1;
    else if (pop && (cnt_q != '0))        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic wr_en;
    assign wr_en = push && (cnt_q == CNT_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (wr_en) begin
        ent_q[e] <= push_lvl;
      end
    end
  end

  logic [CNT_W-1:0] top_ptr;
  assign top_ptr = cnt_q - 1'b1;
  assign active  = (cnt_q != '0);
  assign top_lvl = active ? ent_q[top_ptr[$clog2(DEPTH)-1:0]] : '0;

  // R8: a push never lands on a full stack
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));

  // R6: each pushed level is strictly more urgent than the one beneath it
  a_r6_strict_nest: assert property (@(posedge clk) disable iff (!rst_n)
    (push && active) |-> (push_lvl < top_lvl));

  // R8: push and pop are never requested together
  a_r8_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC     = 55,
  parameter int STK_DEPTH = 8,
  parameter int IDX_W     = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_mask,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic             cpu_id,
  input  logic             cpu_np,
  input  logic             eoi,
  output logic             ack_valid,
  output logic [IDX_W-1:0] ack_src,
  output logic [LVL_W-1:0] ack_lvl,
  output logic             svc_active,
  output logic [LVL_W-1:0] svc_lvl
);

  logic [N_SRC-1:0]            pend, mask, cand;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        found;
  logic [IDX_W-1:0]            win_idx;
  lvl_t                        win_lvl;
  logic                        stk_active;
  lvl_t                        stk_top;
  logic                        fire, pop;
  logic                        ack_valid_q;
  logic [IDX_W-1:0]            ack_src_q;
  lvl_t                        ack_lvl_q;

  irq_src_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_mask (cfg_mask),
    .cfg_lvl  (cfg_lvl),
    .clr      (fire),
    .clr_idx  (win_idx),
    .pend     (pend),
    .mask     (mask),
    .lvl      (lvl)
  );

  assign cand = pend & ~mask;

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .cand    (cand),
    .lvl     (lvl),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  always_comb begin
    fire = found && !cpu_id && !cpu_np && !eoi &&
           (!stk_active || (win_lvl < stk_top));
    pop  = eoi && stk_active;
  end

  irq_svc_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fire),
    .push_lvl (win_lvl),
    .pop      (pop),
    .active   (stk_active),
    .top_lvl  (stk_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_q <= 1'b0;
    end else begin
      ack_valid_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_src_q <= '0;
      ack_lvl_q <= '0;
    end else if (fire) begin
      ack_src_q <= win_idx;
      ack_lvl_q <= win_lvl;
    end
  end

  assign ack_valid  = ack_valid_q;
  assign ack_src    = ack_src_q;
  assign ack_lvl    = ack_lvl_q;
  assign svc_active = stk_active;
  assign svc_lvl    = stk_top;

  // R5: disabled or busy core sees no acknowledge on the next cycle
  a_r5_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_id || cpu_np) |=> !ack_valid);

  // R8: the acknowledged level is what sits on top of the stack
  a_r8_ack_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (svc_active && (svc_lvl == ack_lvl)));

  // R8: an eoi cycle never produces an acknowledge
  a_r8_eoi_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !ack_valid);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  logic        clk;
  logic        rst_n;
  logic [54:0] irq_req;
  logic        cfg_we;
  logic [5:0]  cfg_idx;
  logic        cfg_mask;
  logic [2:0]  cfg_lvl;
  logic        cpu_id, cpu_np, eoi;
  logic        ack_valid;
  logic [5:0]  ack_src;
  logic [2:0]  ack_lvl;
  logic        svc_active;
  logic [2:0]  svc_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .cfg_lvl(cfg_lvl),
    .cpu_id(cpu_id), .cpu_np(cpu_np), .eoi(eoi), .ack_valid(ack_valid),
    .ack_src(ack_src), .ack_lvl(ack_lvl), .svc_active(svc_active),
    .svc_lvl(svc_lvl)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(int idx, bit m, int l);
    cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_mask = m; cfg_lvl = 3'(l);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse(int idx);
    irq_req[idx] = 1'b1;
    step();
    irq_req[idx] = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  task automatic exp_ack(string tag, int src, int l);
    chk({tag, " ack_valid"}, ack_valid, 1);
    chk({tag, " ack_src"}, ack_src, src);
    chk({tag, " ack_lvl"}, ack_lvl, l);
  endtask

  task automatic exp_none(string tag);
    chk({tag, " no ack"}, ack_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 svc_active", svc_active, 0);
    pulse(3);
    step(); exp_none("R1 masked at reset");
    cfg(3, 0, 7);
    step(); exp_ack("R1 default level", 3, 7);
    do_eoi();
    cfg(3, 1, 7);
  endtask

  task automatic t_mask();
    cfg(20, 1, 2);
    pulse(20);
    step(); exp_none("R2 masked");
    step(); exp_none("R2 masked still");
    cfg(20, 0, 2);
    step(); exp_ack("R2 after unmask", 20, 2);
    step(); exp_none("R7 single pulse");
    do_eoi();
    chk("R8 pop to empty", svc_active, 0);
    step(); exp_none("R7 pending cleared");
  endtask

  task automatic t_level();
    cfg(2, 0, 4);
    cfg(40, 0, 1);
    irq_req[2] = 1'b1; irq_req[40] = 1'b1;
    step();
    irq_req = '0;
    step(); exp_ack("R3 lower level wins", 40, 1);
    chk("R8 svc_lvl", svc_lvl, 1);
    step(); exp_none("R6 worse level waits");
    do_eoi();
    step(); exp_ack("R3 next pending", 2, 4);
    do_eoi();
  endtask

  task automatic t_tie();
    cfg(9, 0, 3);
    cfg(5, 0, 3);
    irq_req[9] = 1'b1; irq_req[5] = 1'b1;
    step();
    irq_req = '0;
    step(); exp_ack("R4 lower index wins", 5, 3);
    do_eoi();
    step(); exp_ack("R4 second of tie", 9, 3);
    do_eoi();
  endtask

  task automatic t_hold();
    cfg(30, 0, 0);
    cpu_id = 1'b1;
    pulse(30);
    step(); exp_none("R5 id held");
    step(); exp_none("R5 id held still");
    cpu_id = 1'b0;
    step(); exp_ack("R5 after id clear", 30, 0);
    do_eoi();
    cpu_np = 1'b1;
    pulse(30);
    step(); exp_none("R5 np held");
    cpu_np = 1'b0;
    step(); exp_ack("R5 after np clear", 30, 0);
    do_eoi();
  endtask

  task automatic t_nest();
    cfg(10, 0, 3);
    cfg(11, 0, 3);
    cfg(12, 0, 2);
    pulse(10);
    step(); exp_ack("R6 first", 10, 3);
    chk("R8 svc_lvl first", svc_lvl, 3);
    pulse(11);
    step(); exp_none("R6 equal level no nest");
    pulse(12);
    step(); exp_ack("R6 higher nests", 12, 2);
    chk("R8 svc_lvl nested", svc_lvl, 2);
    do_eoi();
    chk("R8 svc_lvl after pop", svc_lvl, 3);
    step(); exp_none("R6 equal still waits");
    do_eoi();
    step(); exp_ack("R6 equal after return", 11, 3);
    do_eoi();
    chk("R8 empty", svc_active, 0);
  endtask

  task automatic t_relatch();
    cfg(50, 0, 5);
    irq_req[50] = 1'b1;
    step();
    step();
    irq_req[50] = 1'b0;
    exp_ack("R7 ack on relatch cycle", 50, 5);
    step(); exp_none("R7 relatched waits at equal level");
    do_eoi();
    step(); exp_ack("R7 relatched request served", 50, 5);
    do_eoi();
    step(); exp_none("R7 nothing left");
  endtask

  task automatic t_stack();
    do_eoi();
    chk("R8 eoi on empty", svc_active, 0);
    cfg(7, 0, 6);
    irq_req[7] = 1'b1;
    step();
    irq_req[7] = 1'b0;
    eoi = 1'b1;
    step(); exp_none("R8 eoi cycle blocks ack");
    eoi = 1'b0;
    step(); exp_ack("R8 ack after eoi", 7, 6);
    do_eoi();
    for (int k = 0; k < 8; k++) begin
      cfg(k, 0, 7 - k);
      pulse(k);
      step(); exp_ack("R8 depth push", k, 7 - k);
      chk("R8 depth svc_lvl", svc_lvl, 7 - k);
    end
    for (int k = 7; k >= 0; k--) begin
      chk("R8 depth top", svc_lvl, 7 - k);
      chk("R8 depth active", svc_active, 1);
      do_eoi();
    end
    chk("R8 depth empty", svc_active, 0);
  endtask

  initial begin
    irq_req = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_mask = 1'b0;
    cfg_lvl = '0; cpu_id = 1'b0; cpu_np = 1'b0; eoi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_level();
    t_tie();
    t_hold();
    t_nest();
    t_relatch();
    t_stack();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule